// File: doc/BRIEF.md
# Flight-Time Compensated Pin Timing Generator

This block is the per-pin timing engine of a vector-based digital tester. Every vector cycle is programmed with three instants: a drive edge, a return edge and a compare strobe. All three are given as times at the device end of the cable, in ticks of the fine timing clock. Each pin holds a loadable external delay, and a fixed internal trace delay is set per pin as a parameter. Their sum is the pin's flight-time offset. Drive and return edges are launched earlier by that offset. The strobe samples the digitized comparator input later by the same offset. Launch and sample instants therefore move apart in opposite directions around the programmed device time.

A burst of `burst_len` vectors runs as a lead-in period, one period per vector and a trailing period. A drive edge that compensates to a negative time lands at the end of the period before its own. A strobe that compensates past the period end lands at the start of the period after its own. The drive output uses return-to-low format. Each strobe produces a per-pin result pulse that carries a fail flag and the cycle index, so failing cycles can be logged.

Vectors are fetched by index. `vec_idx` names the vector that is captured at the next period boundary, and the stimulus source presents that vector's data on `vec_drv` and `vec_exp`.

Top module: `ftc_pin_timing`

## Requirements
- R1: After reset the pin outputs are low, no result is valid, `busy` is low and `off_wr_err` is low.
- R2: A pin's offset is its trace delay parameter plus its loaded external delay. For vector c, the drive output rises one clock after run state (c+1)*P + t_drive - offset when the vector's drive bit is 1. Run state 0 is the first clock after `start` is sampled, and P is the period in ticks.
- R3: Return-to-low: the pin falls one clock after run state (c+1)*P + t_return - offset. A vector whose drive bit is 0 leaves the pin low for the whole cycle.
- R4: When t_drive or t_return is smaller than the offset, the edge is launched at tick P + t - offset of the previous period. For vector 0, that is the lead-in period.
- R5: The comparator input is sampled in run state (c+1)*P + t_strobe + offset. The matching `res_valid` bit pulses for one clock, one clock after the sample.
- R6: When t_strobe + offset reaches P, the sample falls at tick t_strobe + offset - P of the following period. For the last vector, that is the trailing period.
- R7: Expected codes are 2 bits wide: 00 expects low, 01 expects high, and 10 or 11 mask the compare. `res_fail` is set with `res_valid` exactly when an unmasked expectation differs from the sampled level.
- R8: `res_cycle` carries the index of the vector that the result belongs to.
- R9: An offset write while `busy` is high is ignored and raises `off_wr_err` for one clock on the next clock. An offset write while idle is stored and raises no error.
- R10: With an external delay of 0, only the trace delay is applied, so edges and strobes are aligned at the calibration plane.
- R11: `busy` is high for (burst_len+2)*P clocks, beginning one clock after `start`. While running, `vec_idx` equals (run state div P) + 1. Vector 0 is captured with `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine timing clock, one tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a burst when idle |
| burst_len | input | CYC_W | Number of vectors in the burst (at least 1) |
| t_drive | input | TICK_W | Device-side drive edge tick |
| t_return | input | TICK_W | Device-side return edge tick |
| t_strobe | input | TICK_W | Device-side strobe tick |
| vec_idx | output | CYC_W | Index of the vector to present |
| vec_drv | input | NUM_PINS | Drive bit per pin of the presented vector |
| vec_exp | input | 2*NUM_PINS | Expected code per pin of the presented vector |
| off_wr_en | input | 1 | External delay write request |
| off_wr_pin | input | PIN_W | Pin selected for the write |
| off_wr_val | input | TICK_W | External delay in ticks |
| off_wr_err | output | 1 | Write rejected because a burst was active |
| busy | output | 1 | Burst in progress |
| pin_drv | output | NUM_PINS | Compensated drive waveform per pin |
| cmp_in | input | NUM_PINS | Digitized comparator level per pin |
| res_valid | output | NUM_PINS | Strobe result pulse per pin |
| res_fail | output | NUM_PINS | Compare failure per pin |
| res_cycle | output | NUM_PINS*CYC_W | Vector index of each pin's result |

## Verification
The assertions assume the timing set is legal: t_drive < t_return < P, t_strobe < P, and every pin's total offset stays below P. Under those conditions every compensated instant lies inside the burst window. The bench draws its random timing sets and external delays only from those ranges. Its directed bursts sit on the bounds: a zero drive time with a large offset, a strobe near the period end, and zero external delay. Timing inputs are changed only while idle, because they are captured with `start`.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

    typedef enum logic [1:0] {
        EXP_LOW  = 2'b00,
        EXP_HIGH = 2'b01,
        EXP_MSK0 = 2'b10,
        EXP_MSK1 = 2'b11
    } exp_code_e;

    typedef struct packed {
        logic       drv;
        logic [1:0] code;
    } vec_slot_t;

    function automatic logic strobe_miss(input logic [1:0] code, input logic lvl);
        case (exp_code_e'(code))
            EXP_LOW:  strobe_miss = lvl;
            EXP_HIGH: strobe_miss = ~lvl;
            default:  strobe_miss = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ftc_seq.sv
module ftc_seq #(
    parameter int PERIOD = 40,
    parameter int TICK_W = 6,
    parameter int CYC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CYC_W-1:0]  burst_len,
    input  logic [TICK_W-1:0] td_i,
    input  logic [TICK_W-1:0] tr_i,
    input  logic [TICK_W-1:0] ts_i,
    output logic              run,
    output logic [TICK_W-1:0] tick,
    output logic              shift,
    output logic [CYC_W-1:0]  vec_idx,
    output logic              cur_ok,
    output logic              nxt_ok,
    output logic              prv_ok,
    output logic [CYC_W-1:0]  cur_cyc,
    output logic [CYC_W-1:0]  prv_cyc,
    output logic [TICK_W-1:0] td_o,
    output logic [TICK_W-1:0] tr_o,
    output logic [TICK_W-1:0] ts_o
);
    localparam int PIDX_W = CYC_W + 1;
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(PERIOD - 1);

    typedef struct packed {
        logic              run;
        logic [TICK_W-1:0] tick;
        logic [PIDX_W-1:0] pidx;
        logic [CYC_W-1:0]  len;
        logic [TICK_W-1:0] td;
        logic [TICK_W-1:0] tr;
        logic [TICK_W-1:0] ts;
    } seq_t;

    seq_t s_d, s_q;
    logic              shift_d;
    logic [PIDX_W-1:0] len_w;

    assign len_w = {1'b0, s_q.len};

    always_comb begin
        s_d     = s_q;
        shift_d = 1'b0;
        if (!s_q.run) begin
            if (start) begin
                s_d.run  = 1'b1;
                s_d.tick = '0;
                s_d.pidx = '0;
                s_d.len  = burst_len;
                s_d.td   = td_i;
                s_d.tr   = tr_i;
                s_d.ts   = ts_i;
                shift_d  = 1'b1;
            end
        end else if (s_q.tick == LAST_TICK) begin
            s_d.tick = '0;
            if (s_q.pidx == len_w + PIDX_W'(1)) begin
                s_d.run = 1'b0;
            end else begin
                s_d.pidx = s_q.pidx + PIDX_W'(1);
                shift_d  = 1'b1;
            end
        end else begin
            s_d.tick = s_q.tick + TICK_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run     = s_q.run;
    assign tick    = s_q.tick;
    assign shift   = shift_d;
    assign vec_idx = s_q.run ? CYC_W'(s_q.pidx + PIDX_W'(1)) : '0;
    assign cur_ok  = s_q.run && (s_q.pidx >= PIDX_W'(1)) && (s_q.pidx <= len_w);
    assign nxt_ok  = s_q.run && (s_q.pidx < len_w);
    assign prv_ok  = s_q.run && (s_q.pidx >= PIDX_W'(2));
    assign cur_cyc = CYC_W'(s_q.pidx - PIDX_W'(1));
    assign prv_cyc = CYC_W'(s_q.pidx - PIDX_W'(2));
    assign td_o    = s_q.td;
    assign tr_o    = s_q.tr;
    assign ts_o    = s_q.ts;
endmodule

// File: rtl/ftc_offset_bank.sv
module ftc_offset_bank #(
    parameter int NUM_PINS = 2,
    parameter int TICK_W   = 6,
    parameter int PIN_W    = 1,
    parameter logic [NUM_PINS*TICK_W-1:0] TRACE_TICKS = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       busy,
    input  logic                       wr_en,
    input  logic [PIN_W-1:0]           wr_pin,
    input  logic [TICK_W-1:0]          wr_val,
    output logic [NUM_PINS*TICK_W-1:0] off_total,
    output logic                       wr_err
);
    typedef struct packed {
        logic [NUM_PINS-1:0][TICK_W-1:0] ext;
        logic                            err;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d     = b_q;
        b_d.err = 1'b0;
        if (wr_en) begin
            if (busy) begin
                b_d.err = 1'b1;
            end else if (int'(wr_pin) < NUM_PINS) begin
                b_d.ext[wr_pin] = wr_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_sum
        assign off_total[p*TICK_W +: TICK_W] =
            TRACE_TICKS[p*TICK_W +: TICK_W] + b_q.ext[p];
    end

    assign wr_err = b_q.err;
endmodule

// File: rtl/ftc_pin_engine.sv
module ftc_pin_engine
    import ftc_pkg::*;
#(
    parameter int PERIOD = 40,
    parameter int TICK_W = 6,
    parameter int CYC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TICK_W-1:0] tick,
    input  logic              shift,
    input  logic              vec_drv,
    input  logic [1:0]        vec_code,
    input  logic              cur_ok,
    input  logic              nxt_ok,
    input  logic              prv_ok,
    input  logic [CYC_W-1:0]  cur_cyc,
    input  logic [CYC_W-1:0]  prv_cyc,
    input  logic [TICK_W-1:0] td,
    input  logic [TICK_W-1:0] tr,
    input  logic [TICK_W-1:0] ts,
    input  logic [TICK_W-1:0] off,
    input  logic              cmp,
    output logic              pin,
    output logic              res_valid,
    output logic              res_fail,
    output logic [CYC_W-1:0]  res_cyc
);
    localparam int W1 = TICK_W + 1;
    localparam logic [W1-1:0] PER_W = W1'(PERIOD);

    typedef struct packed {
        vec_slot_t        prv;
        vec_slot_t        cur;
        vec_slot_t        nxt;
        logic             pin;
        logic             rv;
        logic             rf;
        logic [CYC_W-1:0] rc;
    } eng_t;

    eng_t e_d, e_q;

    logic [W1-1:0] off_w, tick_w;
    logic          drv_early, ret_early, stb_late;
    logic [W1-1:0] drv_at, ret_at, stb_sum, stb_at;
    logic          rise_ev, fall_ev, stb_ev;
    logic [1:0]    stb_code;

    assign off_w  = {1'b0, off};
    assign tick_w = {1'b0, tick};

    // Launch instants move earlier by the offset, wrapping into the period before.
    assign drv_early = td < off;
    assign ret_early = tr < off;
    assign drv_at    = drv_early ? ({1'b0, td} + PER_W - off_w) : ({1'b0, td} - off_w);
    assign ret_at    = ret_early ? ({1'b0, tr} + PER_W - off_w) : ({1'b0, tr} - off_w);

    // Sample instant moves later by the offset, wrapping into the period after.
    assign stb_sum  = {1'b0, ts} + off_w;
    assign stb_late = stb_sum >= PER_W;
    assign stb_at   = stb_late ? (stb_sum - PER_W) : stb_sum;

    assign rise_ev  = run && (tick_w == drv_at) &&
                      (drv_early ? (nxt_ok && e_q.nxt.drv) : (cur_ok && e_q.cur.drv));
    assign fall_ev  = run && (tick_w == ret_at) && (ret_early ? nxt_ok : cur_ok);
    assign stb_ev   = run && (tick_w == stb_at) && (stb_late ? prv_ok : cur_ok);
    assign stb_code = stb_late ? e_q.prv.code : e_q.cur.code;

    always_comb begin
        e_d = e_q;
        if (shift) begin
            e_d.prv = e_q.cur;
            e_d.cur = e_q.nxt;
            e_d.nxt = '{drv: vec_drv, code: vec_code};
        end
        if (!run)         e_d.pin = 1'b0;
        else if (rise_ev) e_d.pin = 1'b1;
        else if (fall_ev) e_d.pin = 1'b0;
        e_d.rv = stb_ev;
        e_d.rf = stb_ev && strobe_miss(stb_code, cmp);
        if (stb_ev) e_d.rc = stb_late ? prv_cyc : cur_cyc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign pin       = e_q.pin;
    assign res_valid = e_q.rv;
    assign res_fail  = e_q.rf;
    assign res_cyc   = e_q.rc;
endmodule

// File: rtl/ftc_pin_timing.sv
module ftc_pin_timing #(
    parameter int NUM_PINS = 2,
    parameter int TICK_W   = 6,
    parameter int PERIOD   = 40,
    parameter int CYC_W    = 8,
    parameter logic [NUM_PINS*TICK_W-1:0] TRACE_TICKS = {6'd3, 6'd2},
    parameter int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [CYC_W-1:0]          burst_len,
    input  logic [TICK_W-1:0]         t_drive,
    input  logic [TICK_W-1:0]         t_return,
    input  logic [TICK_W-1:0]         t_strobe,
    output logic [CYC_W-1:0]          vec_idx,
    input  logic [NUM_PINS-1:0]       vec_drv,
    input  logic [2*NUM_PINS-1:0]     vec_exp,
    input  logic                      off_wr_en,
    input  logic [PIN_W-1:0]          off_wr_pin,
    input  logic [TICK_W-1:0]         off_wr_val,
    output logic                      off_wr_err,
    output logic                      busy,
    output logic [NUM_PINS-1:0]       pin_drv,
    input  logic [NUM_PINS-1:0]       cmp_in,
    output logic [NUM_PINS-1:0]       res_valid,
    output logic [NUM_PINS-1:0]       res_fail,
    output logic [NUM_PINS*CYC_W-1:0] res_cycle
);
    logic                       run, shift;
    logic [TICK_W-1:0]          tick, td, tr, ts;
    logic                       cur_ok, nxt_ok, prv_ok;
    logic [CYC_W-1:0]           cur_cyc, prv_cyc;
    logic [NUM_PINS*TICK_W-1:0] off_total;

    ftc_seq #(.PERIOD(PERIOD), .TICK_W(TICK_W), .CYC_W(CYC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .burst_len(burst_len),
        .td_i(t_drive), .tr_i(t_return), .ts_i(t_strobe),
        .run(run), .tick(tick), .shift(shift), .vec_idx(vec_idx),
        .cur_ok(cur_ok), .nxt_ok(nxt_ok), .prv_ok(prv_ok),
        .cur_cyc(cur_cyc), .prv_cyc(prv_cyc),
        .td_o(td), .tr_o(tr), .ts_o(ts)
    );

    ftc_offset_bank #(.NUM_PINS(NUM_PINS), .TICK_W(TICK_W), .PIN_W(PIN_W),
                      .TRACE_TICKS(TRACE_TICKS)) u_bank (
        .clk(clk), .rst_n(rst_n), .busy(run), .wr_en(off_wr_en),
        .wr_pin(off_wr_pin), .wr_val(off_wr_val),
        .off_total(off_total), .wr_err(off_wr_err)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        ftc_pin_engine #(.PERIOD(PERIOD), .TICK_W(TICK_W), .CYC_W(CYC_W)) u_eng (
            .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .shift(shift),
            .vec_drv(vec_drv[p]), .vec_code(vec_exp[2*p +: 2]),
            .cur_ok(cur_ok), .nxt_ok(nxt_ok), .prv_ok(prv_ok),
            .cur_cyc(cur_cyc), .prv_cyc(prv_cyc),
            .td(td), .tr(tr), .ts(ts), .off(off_total[p*TICK_W +: TICK_W]),
            .cmp(cmp_in[p]),
            .pin(pin_drv[p]), .res_valid(res_valid[p]), .res_fail(res_fail[p]),
            .res_cyc(res_cycle[p*CYC_W +: CYC_W])
        );
    end

    assign busy = run;
endmodule

// File: rtl/ftc_pin_timing_chk.sv
module ftc_pin_timing_chk #(
    parameter int NUM_PINS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                off_wr_en,
    input logic                off_wr_err,
    input logic [NUM_PINS-1:0] pin_drv,
    input logic [NUM_PINS-1:0] res_valid,
    input logic [NUM_PINS-1:0] res_fail
);
    AST_IDLE_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pin_drv == '0)) else $error("idle pin high"); // R1

    AST_RESULT_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid != '0) |-> busy) else $error("result outside burst"); // R5

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid != '0) |=> ((res_valid & $past(res_valid)) == '0)) else $error("result held"); // R5

    AST_FAIL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_fail & ~res_valid) == '0) else $error("fail without result"); // R7

    AST_ERR_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        off_wr_err |-> $past(busy && off_wr_en)) else $error("spurious write error"); // R9

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)) else $error("burst without start"); // R11

    AST_RISE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_drv & ~$past(pin_drv)) != '0) |-> busy) else $error("edge outside burst"); // R2
endmodule

bind ftc_pin_timing ftc_pin_timing_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .off_wr_en(off_wr_en), .off_wr_err(off_wr_err),
    .pin_drv(pin_drv), .res_valid(res_valid), .res_fail(res_fail)
);

// File: tb/ftc_pin_timing_tb.sv
module ftc_pin_timing_tb;
    localparam int NP   = 2;
    localparam int TW   = 6;
    localparam int P    = 40;
    localparam int CW   = 8;
    localparam int MAXL = 8;
    localparam int HIST = (MAXL + 2) * P;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [CW-1:0] burst_len = '0;
    logic [TW-1:0] t_drive = '0, t_return = '0, t_strobe = '0;
    logic [CW-1:0] vec_idx;
    logic [NP-1:0] vec_drv;
    logic [2*NP-1:0] vec_exp;
    logic off_wr_en = 1'b0;
    logic [0:0] off_wr_pin = '0;
    logic [TW-1:0] off_wr_val = '0;
    logic off_wr_err, busy;
    logic [NP-1:0] pin_drv, res_valid, res_fail;
    logic [NP-1:0] cmp_in = '0;
    logic [NP*CW-1:0] res_cycle;

    int errors = 0, checks = 0;
    bit done = 0;
    int trace_m [NP] = '{2, 3};
    int ext_m [NP];
    logic vd [MAXL][NP];
    logic [1:0] vc [MAXL][NP];
    logic cmp_hist [HIST][NP];

    always #10 clk = ~clk;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            vec_drv[p]       = (int'(vec_idx) < MAXL) ? vd[vec_idx][p] : 1'b0;
            vec_exp[2*p +: 2] = (int'(vec_idx) < MAXL) ? vc[vec_idx][p] : 2'b10;
        end
    end

    ftc_pin_timing u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .burst_len(burst_len),
        .t_drive(t_drive), .t_return(t_return), .t_strobe(t_strobe),
        .vec_idx(vec_idx), .vec_drv(vec_drv), .vec_exp(vec_exp),
        .off_wr_en(off_wr_en), .off_wr_pin(off_wr_pin), .off_wr_val(off_wr_val),
        .off_wr_err(off_wr_err), .busy(busy), .pin_drv(pin_drv), .cmp_in(cmp_in),
        .res_valid(res_valid), .res_fail(res_fail), .res_cycle(res_cycle)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit miss_of(input logic [1:0] code, input logic lvl);
        if (code[1]) return 1'b0;
        return code[0] ? !lvl : lvl;
    endfunction

    function automatic int offset_of(input int p);
        return trace_m[p] + ext_m[p];
    endfunction

    function automatic bit pin_model(input int p, input int n, input int L);
        for (int c = 0; c < L; c++) begin
            int rs, fs;
            rs = (c + 1) * P + int'(t_drive) - offset_of(p);
            fs = (c + 1) * P + int'(t_return) - offset_of(p);
            if (vd[c][p] && rs < n && n <= fs) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic write_off(input int p, input int v);
        @(negedge clk);
        off_wr_en = 1'b1; off_wr_pin = 1'(p); off_wr_val = TW'(v);
        @(negedge clk);
        off_wr_en = 1'b0;
        ext_m[p] = v;
        chk(off_wr_err == 1'b0, "R9 idle write no error", int'(off_wr_err), 0);
    endtask

    task automatic fill_vectors(input int L);
        for (int c = 0; c < L; c++)
            for (int p = 0; p < NP; p++) begin
                vd[c][p] = 1'($urandom_range(0, 1));
                vc[c][p] = 2'($urandom_range(0, 3));
            end
    endtask

    task automatic run_burst(input int L, input int td, input int tr, input int ts, input bit bad_wr);
        int total;
        total = (L + 2) * P;
        @(negedge clk);
        burst_len = CW'(L); t_drive = TW'(td); t_return = TW'(tr); t_strobe = TW'(ts);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n <= total; n++) begin
            // R11 busy window and vector index
            chk(busy == (n < total), "R11 busy", int'(busy), int'(n < total));
            if (n < total)
                chk(int'(vec_idx) == n / P + 1, "R11 vec_idx", int'(vec_idx), n / P + 1);
            // R9 rejected write flags error one clock later
            chk(off_wr_err == (bad_wr && n == 8), "R9 busy write error", int'(off_wr_err),
                int'(bad_wr && n == 8));
            for (int p = 0; p < NP; p++) begin
                bit ev, ef;
                int ec;
                // R2 R3 R4 R10 compensated return-to-low drive
                chk(pin_drv[p] == pin_model(p, n, L), "R2 R3 R4 R10 pin level",
                    int'(pin_drv[p]), int'(pin_model(p, n, L)));
                ev = 0; ef = 0; ec = 0;
                for (int c = 0; c < L; c++) begin
                    int ss;
                    ss = (c + 1) * P + ts + offset_of(p);
                    if (n - 1 == ss) begin
                        ev = 1; ec = c;
                        ef = miss_of(vc[c][p], cmp_hist[ss][p]);
                    end
                end
                // R5 R6 strobe instant
                chk(res_valid[p] == ev, "R5 R6 result valid", int'(res_valid[p]), int'(ev));
                if (ev && res_valid[p]) begin
                    chk(res_fail[p] == ef, "R7 fail flag", int'(res_fail[p]), int'(ef));
                    chk(int'(res_cycle[p*CW +: CW]) == ec, "R8 cycle index",
                        int'(res_cycle[p*CW +: CW]), ec);
                end
            end
            off_wr_en = 1'b0;
            if (bad_wr && n == 7) begin
                off_wr_en = 1'b1; off_wr_pin = 1'b0; off_wr_val = TW'(9);
            end
            for (int p = 0; p < NP; p++) begin
                cmp_in[p] = 1'($urandom_range(0, 1));
                if (n < HIST) cmp_hist[n][p] = cmp_in[p];
            end
            @(negedge clk);
        end
        off_wr_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        ext_m = '{0, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pin_drv == '0, "R1 reset pin", int'(pin_drv), 0);
        chk(res_valid == '0, "R1 reset valid", int'(res_valid), 0);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(off_wr_err == 1'b0, "R1 reset err", int'(off_wr_err), 0);

        // R10 no external delay: trace only
        fill_vectors(3);
        run_burst(3, 5, 20, 10, 0);

        // R4 R6 drive wraps early, strobe wraps late
        write_off(0, 30);
        write_off(1, 20);
        fill_vectors(4);
        run_burst(4, 0, 10, 35, 0);

        // R9 write during burst is ignored, timing keeps old offset
        fill_vectors(3);
        run_burst(3, 4, 30, 39, 1);
        fill_vectors(2);
        run_burst(2, 2, 12, 0, 0);

        // R7 all codes masked on pin 1, forced drive ones
        fill_vectors(2);
        for (int c = 0; c < 2; c++) begin vc[c][1] = 2'b11; vd[c][0] = 1'b1; end
        run_burst(2, 1, 39, 20, 0);

        // random timing sets
        for (int k = 0; k < 8; k++) begin
            int L, td, tr, ts;
            L  = $urandom_range(1, MAXL);
            td = $urandom_range(0, P - 2);
            tr = $urandom_range(td + 1, P - 1);
            ts = $urandom_range(0, P - 1);
            for (int p = 0; p < NP; p++) write_off(p, $urandom_range(0, P - 1 - trace_m[p]));
            fill_vectors(L);
            run_burst(L, td, tr, ts, k[0]);
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule